// File: doc/BRIEF.md
# Microcoded Multicycle Controller

This block sequences the control signals of a multicycle datapath for a small 32-bit RISC subset. The supported instructions are word load, word store, register-format ALU operations, branch-if-equal and jump. A micro program counter indexes a small microcode store. Each word of the store sets the datapath controls for one cycle. Each word also carries a sequencing code that picks the next micro address.

There are three ways to leave a step:
- advance to the next micro address;
- go back to the fetch step;
- take a target from one of two opcode-indexed dispatch tables.

The first table is consulted after instruction decode. The second is consulted after the memory-address step, where it separates loads from stores. An opcode that is missing from a table leads back to fetch.

The datapath, memory and register file sit outside the block. The only input besides clock and synchronous reset is the 6-bit opcode field of the instruction register.

Top module: `ucode_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the controller is placed at the fetch step, and its outputs show the fetch pattern in the cycle that follows.
- R2: The fetch step asserts exactly `mem_rd`=1, `ir_wr`=1 and `pc_wr`=1, with `addr_sel`=0 (address from the PC), `alu_a_sel`=0 (PC), `alu_b_sel`=01 (constant 4), `alu_op`=00 (add) and `pc_src`=00 (ALU result). Every other output is 0. The decode step always follows, and every instruction path ends by returning to fetch.
- R3: The decode step asserts no write or memory strobe. It sets `alu_a_sel`=0, `alu_b_sel`=11 (shifted sign-extended immediate) and `alu_op`=00. It then dispatches on the opcode through table 1.
- R4: For opcode 0x23 (load), the steps after decode are as follows:
  - memory address: `alu_a_sel`=1, `alu_b_sel`=10 (sign-extended immediate), `alu_op`=00;
  - memory read: `mem_rd`=1, `addr_sel`=1;
  - write-back: `rf_wr`=1, `wb_src`=1 (memory data), `rf_dst`=0;
  - then fetch.
- R5: For opcode 0x2B (store), the steps after decode are the memory-address step, then `mem_wr`=1 with `addr_sel`=1, then fetch.
- R6: For opcode 0x00 (register format), the steps after decode are as follows:
  - execute: `alu_a_sel`=1, `alu_b_sel`=00 (B), `alu_op`=10 (function field);
  - write-back: `rf_wr`=1, `rf_dst`=1, `wb_src`=0;
  - then fetch.
- R7: For opcode 0x04 (branch), a single step follows decode. It sets `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01 (subtract), `pc_wr_cond`=1 and `pc_src`=01 (saved ALU output). Fetch comes next.
- R8: For opcode 0x02 (jump), a single step follows decode. It sets `pc_wr`=1 and `pc_src`=10 (jump address), and fetch comes next.
- R9: An opcode with no entry in table 1, sampled during decode, sends the controller straight to fetch. No write is asserted on the way.
- R10: `mem_rd` and `mem_wr` are never high together, and `pc_wr` and `pc_wr_cond` are never high together.
- R11: The opcode is consulted only in the decode and memory-address steps. Its value during the other steps has no effect. An opcode other than 0x23 or 0x2B during the memory-address step leads to fetch.
- R12: A reset raised in the middle of an instruction abandons it, and the next cycle is the fetch step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address source: 0 PC, 1 saved ALU output |
| ir_wr | output | 1 | Instruction register load |
| rf_wr | output | 1 | Register file write |
| rf_dst | output | 1 | Destination register field: 0 rt, 1 rd |
| wb_src | output | 1 | Write-back data: 0 saved ALU output, 1 memory data |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 B, 01 four, 10 immediate, 11 immediate shifted |
| alu_op | output | 2 | 00 add, 01 subtract, 10 from function field |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write if the ALU reports equality |
| pc_src | output | 2 | PC source: 00 ALU result, 01 saved ALU output, 10 jump address |

## Verification
The bench aims at the opcode timing. It changes the opcode during fetch, between decode and the memory-address step, and afterwards.

A design that sampled the opcode in the wrong step would take the wrong path:
- one that reused the first dispatch table after address calculation would send an address-time change of opcode to the branch or jump step instead of fetch;
- one that sampled the opcode during fetch would follow the value present in that step instead of the one present at decode.

Unknown opcodes check that a missing table entry falls through to fetch rather than to a neighbouring step. A reset in mid-load checks that the partly completed memory sequence is dropped.

// File: rtl/ucode_ctrl.sv
module ucode_ctrl #(
  parameter int OPC_W = 6,
  parameter int UPC_W = 4,
  parameter logic [OPC_W-1:0] OP_RFMT = 6'h00,
  parameter logic [OPC_W-1:0] OP_LW   = 6'h23,
  parameter logic [OPC_W-1:0] OP_SW   = 6'h2B,
  parameter logic [OPC_W-1:0] OP_BEQ  = 6'h04,
  parameter logic [OPC_W-1:0] OP_JMP  = 6'h02
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             addr_sel,
  output logic             ir_wr,
  output logic             rf_wr,
  output logic             rf_dst,
  output logic             wb_src,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       alu_op,
  output logic             pc_wr,
  output logic             pc_wr_cond,
  output logic [1:0]       pc_src
);

  localparam logic [UPC_W-1:0] U_FETCH = 0, U_DECODE = 1, U_MADDR = 2,
    U_LDRD = 3, U_LDWB = 4, U_STWR = 5, U_REXE = 6, U_RWB = 7,
    U_BEQ = 8, U_JMP = 9;
  localparam logic [1:0] SQ_NEXT = 2'd0, SQ_FETCH = 2'd1, SQ_TBL1 = 2'd2, SQ_TBL2 = 2'd3;
  localparam logic [1:0] B_REG = 2'd0, B_FOUR = 2'd1, B_IMM = 2'd2, B_IMMSH = 2'd3;
  localparam logic [1:0] A_ADD = 2'd0, A_SUB = 2'd1, A_FUNC = 2'd2;
  localparam logic [1:0] P_ALU = 2'd0, P_OUT = 2'd1, P_JMP = 2'd2;
  localparam int CTL_W = 16;
  localparam int UW = CTL_W + 2;

  // word layout: seq | rd wr asel irw rfw dst wb a | b(2) op(2) | pcw pcc | pcs(2)
  function automatic logic [UW-1:0] urom(input logic [UPC_W-1:0] a);
    case (a)
      U_FETCH:  urom = {SQ_NEXT,  8'b1001_0000, B_FOUR,  A_ADD,  2'b10, P_ALU};
      U_DECODE: urom = {SQ_TBL1,  8'b0000_0000, B_IMMSH, A_ADD,  2'b00, P_ALU};
      U_MADDR:  urom = {SQ_TBL2,  8'b0000_0001, B_IMM,   A_ADD,  2'b00, P_ALU};
      U_LDRD:   urom = {SQ_NEXT,  8'b1010_0000, B_REG,   A_ADD,  2'b00, P_ALU};
      U_LDWB:   urom = {SQ_FETCH, 8'b0000_1010, B_REG,   A_ADD,  2'b00, P_ALU};
      U_STWR:   urom = {SQ_FETCH, 8'b0110_0000, B_REG,   A_ADD,  2'b00, P_ALU};
      U_REXE:   urom = {SQ_NEXT,  8'b0000_0001, B_REG,   A_FUNC, 2'b00, P_ALU};
      U_RWB:    urom = {SQ_FETCH, 8'b0000_1100, B_REG,   A_ADD,  2'b00, P_ALU};
      U_BEQ:    urom = {SQ_FETCH, 8'b0000_0001, B_REG,   A_SUB,  2'b01, P_OUT};
      U_JMP:    urom = {SQ_FETCH, 8'b0000_0000, B_REG,   A_ADD,  2'b10, P_JMP};
      default:  urom = {SQ_FETCH, {CTL_W{1'b0}}};
    endcase
  endfunction

  function automatic logic [UPC_W-1:0] tbl1(input logic [OPC_W-1:0] op);
    if (op == OP_LW || op == OP_SW) tbl1 = U_MADDR;
    else if (op == OP_RFMT)         tbl1 = U_REXE;
    else if (op == OP_BEQ)          tbl1 = U_BEQ;
    else if (op == OP_JMP)          tbl1 = U_JMP;
    else                            tbl1 = U_FETCH;
  endfunction

  function automatic logic [UPC_W-1:0] tbl2(input logic [OPC_W-1:0] op);
    if (op == OP_LW)      tbl2 = U_LDRD;
    else if (op == OP_SW) tbl2 = U_STWR;
    else                  tbl2 = U_FETCH;
  endfunction

  logic [UPC_W-1:0] upc, upc_nx;
  logic [UW-1:0]    uword;
  logic [1:0]       seq;

  assign uword = urom(upc);
  assign {seq, mem_rd, mem_wr, addr_sel, ir_wr, rf_wr, rf_dst, wb_src, alu_a_sel,
          alu_b_sel, alu_op, pc_wr, pc_wr_cond, pc_src} = uword;

  always_comb begin
    case (seq)
      SQ_NEXT: upc_nx = upc + 1'b1;
      SQ_TBL1: upc_nx = tbl1(opcode);
      SQ_TBL2: upc_nx = tbl2(opcode);
      default: upc_nx = U_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) upc <= U_FETCH;
    else     upc <= upc_nx;
  end

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  reset_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (ir_wr && mem_rd && pc_wr && !addr_sel));

  // R2
  refetch_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_wr || mem_wr || pc_wr_cond || (pc_wr && pc_src == P_JMP)) |=> (ir_wr && mem_rd && !addr_sel));

  // R3
  decode_chk: assert property (@(posedge clk) disable iff (rst)
    ir_wr |=> (!ir_wr && !pc_wr && !mem_rd && !rf_wr && alu_b_sel == B_IMMSH));

  // R4
  load_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && addr_sel) |=> (rf_wr && wb_src && !rf_dst));

  // R6
  rfmt_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_op == A_FUNC) |=> (rf_wr && rf_dst && !wb_src));

  // R7
  branch_chk: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |-> (alu_op == A_SUB && pc_src == P_OUT && !pc_wr));

  // R10
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr));

  // R10
  pc_excl_chk: assert property (@(posedge clk) disable iff (rst) !(pc_wr && pc_wr_cond));

endmodule

// File: tb/test_ucode_ctrl.sv
module test_ucode_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic mem_rd, mem_wr, addr_sel, ir_wr, rf_wr, rf_dst, wb_src, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src;
  logic pc_wr, pc_wr_cond;

  always #4 clk = ~clk;

  ucode_ctrl i_ucode_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_wr(ir_wr),
    .rf_wr(rf_wr), .rf_dst(rf_dst), .wb_src(wb_src), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_wr(pc_wr),
    .pc_wr_cond(pc_wr_cond), .pc_src(pc_src)
  );

  logic [15:0] obs;
  assign obs = {mem_rd, mem_wr, addr_sel, ir_wr, rf_wr, rf_dst, wb_src, alu_a_sel,
                alu_b_sel, alu_op, pc_wr, pc_wr_cond, pc_src};

  int n_tests = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  function automatic logic [15:0] mk(input logic rd, wr, as, irw, rfw, dst, wb, a,
      input logic [1:0] b, op, input logic pcw, pcc, input logic [1:0] pcs);
    return {rd, wr, as, irw, rfw, dst, wb, a, b, op, pcw, pcc, pcs};
  endfunction

  logic [15:0] V_F, V_D, V_MA, V_LR, V_LW, V_SW, V_RE, V_RW, V_BQ, V_JP;
  initial begin
    V_F  = mk(1,0,0,1,0,0,0,0,2'b01,2'b00,1,0,2'b00);
    V_D  = mk(0,0,0,0,0,0,0,0,2'b11,2'b00,0,0,2'b00);
    V_MA = mk(0,0,0,0,0,0,0,1,2'b10,2'b00,0,0,2'b00);
    V_LR = mk(1,0,1,0,0,0,0,0,2'b00,2'b00,0,0,2'b00);
    V_LW = mk(0,0,0,0,1,0,1,0,2'b00,2'b00,0,0,2'b00);
    V_SW = mk(0,1,1,0,0,0,0,0,2'b00,2'b00,0,0,2'b00);
    V_RE = mk(0,0,0,0,0,0,0,1,2'b00,2'b10,0,0,2'b00);
    V_RW = mk(0,0,0,0,1,1,0,0,2'b00,2'b00,0,0,2'b00);
    V_BQ = mk(0,0,0,0,0,0,0,1,2'b00,2'b01,0,1,2'b01);
    V_JP = mk(0,0,0,0,0,0,0,0,2'b00,2'b00,1,0,2'b10);
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic push(input string tag, input logic [15:0] v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    logic [15:0] e;
    string t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, obs, e);
      n_tests++;
      if ((mem_rd && mem_wr) || (pc_wr && pc_wr_cond)) begin
        n_fail++;
        $display("FAIL R10: exclusive strobes together, got %b expected none", obs);
      end
    end
  end

  task automatic run(input string tag, input logic [5:0] opf, opd, opm);
    push({tag, " R2 fetch"}, V_F);
    push({tag, " R3 decode"}, V_D);
    case (opd)
      6'h23, 6'h2B: begin
        push({tag, " R4 maddr"}, V_MA);
        if (opm == 6'h23) begin
          push({tag, " R4 load read"}, V_LR);
          push({tag, " R4 load wb"}, V_LW);
        end else if (opm == 6'h2B) begin
          push({tag, " R5 store"}, V_SW);
        end
      end
      6'h00: begin
        push({tag, " R6 exec"}, V_RE);
        push({tag, " R6 wb"}, V_RW);
      end
      6'h04: push({tag, " R7 branch"}, V_BQ);
      6'h02: push({tag, " R8 jump"}, V_JP);
      default: ;
    endcase
    opcode = opf;
    @(posedge clk); #1;
    opcode = opd;
    @(posedge clk); #1;
    opcode = opm;
    if (exp_q.size() > 0) begin
      wait (exp_q.size() == 0);
      @(posedge clk); #1;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", obs, V_F);
    rst = 1'b0;
    run("R4 load",  6'h23, 6'h23, 6'h23);
    run("R5 store", 6'h2B, 6'h2B, 6'h2B);
    run("R6 rfmt",  6'h00, 6'h00, 6'h00);
    run("R7 beq",   6'h04, 6'h04, 6'h04);
    run("R8 jump",  6'h02, 6'h02, 6'h02);
    run("R9 unknown 3F", 6'h3F, 6'h3F, 6'h3F);
    run("R9 unknown 08", 6'h08, 6'h08, 6'h08);
    run("R11 fetch ignored", 6'h02, 6'h23, 6'h2B);
    run("R11 maddr nonmem", 6'h00, 6'h23, 6'h04);
    run("R11 beq then change", 6'h23, 6'h04, 6'h02);
    run("R4 load again", 6'h23, 6'h23, 6'h23);
    run("R11 store to load", 6'h2B, 6'h2B, 6'h23);
    opcode = 6'h23;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    check("R12 reset mid-load", obs, V_F);
    run("R12 after reset", 6'h00, 6'h00, 6'h00);
    run("R8 final jump", 6'h02, 6'h02, 6'h02);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule